// File: doc/BRIEF.md
# Frame-Loss Defect Monitor

This block sits behind the framer of a byte-serial STS-3 receive path, where frame alignment has already been found. A frame-start marker flags the first framing byte of each frame. The block compares the six framing bytes of every frame with the expected pattern, which is three bytes of 0xF6 followed by three bytes of 0x28. From the run of good and errored frames it keeps two defects. The first is Severely Errored Frame (SEF), which is raised after several errored frames in a row and dropped after a few clean ones. The second is Loss Of Frame (LOF), which is raised when SEF has lasted a programmable number of frames and dropped when the stream has stayed clean for the same number of frames.

A loss-of-signal indication from upstream is registered and reported next to the two framing defects. All three appear as read-only bits in a status byte. Each change of a defect, whether it is raised or dropped, sets a sticky bit in an interrupt byte. Reading the interrupt byte clears it. An active-low interrupt line stays asserted while any pending interrupt bit that is enabled by a per-bit mask remains set.

Top module: `frm_loss_mon`

## Requirements
- R1: After a synchronous reset, the status byte and the interrupt byte both read 0x00, and `irq_n_o` is high.
- R2: A frame opens when `fsync_i` and `byte_vld_i` are both high; that byte is the first framing byte. The next five valid bytes are the rest of the frame. Bytes 1–3 must equal 0xF6 and bytes 4–6 must equal 0x28. A single wrong bit in any of the six bytes makes the frame errored.
- R3: A run of three or fewer errored frames that is broken by a correct frame leaves SEF at 0.
- R4: The fourth errored frame in a row sets SEF (status bit 1) while the block is in the in-frame state.
- R5: While SEF is 1, two correct frames in a row clear it. An errored frame restarts that count.
- R6: LOF (status bit 2) is set at the LOF_FRAMES-th frame (default 24) that is judged after SEF was raised, provided SEF stays 1 throughout. If SEF clears earlier, the count restarts.
- R7: While LOF is 1, it clears at the LOF_FRAMES-th frame that is judged after SEF cleared, provided SEF stays 0 throughout.
- R8: Every change of LOS, SEF or LOF, whether rising or falling, sets the interrupt bit at the same position (bit 0, 1 or 2).
- R9: A read of address 1 returns the interrupt byte and clears the bits it returned. A change that lands on the same clock as that read is kept for the next read. A read of address 0 returns the status byte and clears nothing.
- R10: `irq_n_o` is low exactly when the interrupt byte ANDed with `int_mask_i` is non-zero. Bits that are masked off still latch.
- R11: Status bit 0 follows `los_i` one clock later.
- R12: Bytes with `byte_vld_i` low are ignored, including their `fsync_i`. Valid bytes outside a frame window are ignored. An `fsync_i` inside an open window discards the partial frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| los_i | input | 1 | Loss-of-signal indication from upstream |
| byte_vld_i | input | 1 | Byte strobe for `byte_i` |
| byte_i | input | 8 | Received data byte |
| fsync_i | input | 1 | Marks the first framing byte of a frame |
| int_mask_i | input | 3 | Per-bit interrupt enable (bit 0 LOS, bit 1 SEF, bit 2 LOF) |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Register address: 0 status, 1 interrupt |
| rd_data_o | output | 8 | Read data, valid the clock after the strobe |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a defect change that sets an interrupt bit on the very clock edge at which software reads and clears the interrupt byte. The bench sends the fourth errored frame and then counts clocks from the edge that accepts its last framing byte, so that the read strobe lands on the edge where the SEF change is recorded. It then checks that this read returns the old contents and that the next read shows the new bit. LOF needs SEF to last through two dozen judged frames, so directed runs of errored and clean frames reach both LOF edges. A long random phase then alternates mostly-clean and mostly-errored stretches, with random byte gaps, random masks and aborted windows.

// File: rtl/frm_loss_pkg.sv
package frm_loss_pkg;
   localparam int DEF_W   = 3;
   localparam int BIT_LOS = 0;
   localparam int BIT_SEF = 1;
   localparam int BIT_LOF = 2;
   localparam int REG_W   = 8;

   typedef enum logic [1:0] {
      ST_INFRAME = 2'd0,
      ST_SEF     = 2'd1,
      ST_LOF     = 2'd2
   } frm_state_e;
endpackage

// File: rtl/frm_align_chk.sv
// Compares the framing bytes of each frame with the expected pattern and
// emits a one-cycle verdict after the last framing byte.
module frm_align_chk #(
   parameter int         A1_COUNT = 3,
   parameter int         A2_COUNT = 3,
   parameter logic [7:0] A1_VAL   = 8'hF6,
   parameter logic [7:0] A2_VAL   = 8'h28
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       byte_vld_i,
   input  logic [7:0] byte_i,
   input  logic       fsync_i,
   output logic       frame_done_o,
   output logic       frame_bad_o
);
   localparam int NBYTES = A1_COUNT + A2_COUNT;
   localparam int POS_W  = $clog2(NBYTES + 1);
   localparam logic [POS_W-1:0] LAST = POS_W'(NBYTES - 1);

   if (A1_COUNT < 1 || A2_COUNT < 1) begin : g_bad_count
      $error("frm_align_chk: both framing byte counts must be at least 1");
   end

   logic [7:0]       exp_tbl [NBYTES];
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] idx;
   logic             acc_bad_q;
   logic             done_q;
   logic             verdict_q;
   logic             in_win;
   logic             mism;

   for (genvar g = 0; g < NBYTES; g++) begin : g_ref
      localparam logic [7:0] EXP_BYTE = (g < A1_COUNT) ? A1_VAL : A2_VAL;
      assign exp_tbl[g] = EXP_BYTE;
   end

   // a frame start always re-opens the window at position zero
   assign idx    = fsync_i ? '0 : pos_q;
   assign in_win = fsync_i || (pos_q != '0);
   assign mism   = (byte_i != exp_tbl[idx]);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q     <= '0;
         acc_bad_q <= 1'b0;
         done_q    <= 1'b0;
         verdict_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (byte_vld_i && in_win) begin
            if (idx == LAST) begin
               pos_q     <= '0;
               done_q    <= 1'b1;
               verdict_q <= acc_bad_q | mism;
            end else begin
               pos_q     <= idx + POS_W'(1);
               acc_bad_q <= (fsync_i ? 1'b0 : acc_bad_q) | mism;
            end
         end
      end
   end

   assign frame_done_o = done_q;
   assign frame_bad_o  = verdict_q;

   // a verdict needs a full window of bytes, so two in a row are impossible
   assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
      frame_done_o |=> !frame_done_o);

   assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
      pos_q <= LAST);

   // a verdict follows only a valid byte that was accepted
   assert_verdict_from_byte_R12: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_done_o) |-> $past(byte_vld_i));
endmodule

// File: rtl/frm_defect_fsm.sv
// SEF / LOF persistence machine driven by per-frame verdicts.
module frm_defect_fsm
   import frm_loss_pkg::*;
#(
   parameter int SEF_SET_FRAMES = 4,
   parameter int SEF_CLR_FRAMES = 2,
   parameter int LOF_FRAMES     = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic frame_done_i,
   input  logic frame_bad_i,
   output logic sef_o,
   output logic lof_o
);
   localparam int RUN_MAX = (SEF_SET_FRAMES > SEF_CLR_FRAMES) ? SEF_SET_FRAMES : SEF_CLR_FRAMES;
   localparam int RUN_W   = $clog2(RUN_MAX + 1);
   localparam int LCNT_W  = $clog2(LOF_FRAMES + 1);
   localparam logic [RUN_W-1:0]  SET_LAST = RUN_W'(SEF_SET_FRAMES - 1);
   localparam logic [RUN_W-1:0]  CLR_LAST = RUN_W'(SEF_CLR_FRAMES - 1);
   localparam logic [LCNT_W-1:0] LOF_LAST = LCNT_W'(LOF_FRAMES - 1);

   if (SEF_SET_FRAMES < 1 || SEF_CLR_FRAMES < 1 || LOF_FRAMES < 1) begin : g_bad_persist
      $error("frm_defect_fsm: persistence counts must be at least 1");
   end

   frm_state_e        state_q, state_n;
   logic              sef_q, sef_n;
   logic              lof_q, lof_n;
   logic [RUN_W-1:0]  run_q, run_n;
   logic [LCNT_W-1:0] lcnt_q, lcnt_n;

   assign lof_q = (state_q == ST_LOF);

   always_comb begin
      sef_n   = sef_q;
      lof_n   = lof_q;
      run_n   = run_q;
      lcnt_n  = lcnt_q;
      state_n = state_q;
      if (frame_done_i) begin
         // SEF: count errored frames while clear, clean frames while set
         if (!sef_q) begin
            if (frame_bad_i) begin
               if (run_q == SET_LAST) begin
                  sef_n = 1'b1;
                  run_n = '0;
               end else begin
                  run_n = run_q + RUN_W'(1);
               end
            end else begin
               run_n = '0;
            end
         end else begin
            if (!frame_bad_i) begin
               if (run_q == CLR_LAST) begin
                  sef_n = 1'b0;
                  run_n = '0;
               end else begin
                  run_n = run_q + RUN_W'(1);
               end
            end else begin
               run_n = '0;
            end
         end
         // LOF: count frames where SEF disagrees with LOF and holds steady
         if (sef_n != sef_q) begin
            lcnt_n = '0;
         end else if (sef_q != lof_q) begin
            if (lcnt_q == LOF_LAST) begin
               lof_n  = !lof_q;
               lcnt_n = '0;
            end else begin
               lcnt_n = lcnt_q + LCNT_W'(1);
            end
         end else begin
            lcnt_n = '0;
         end
         state_n = lof_n ? ST_LOF : (sef_n ? ST_SEF : ST_INFRAME);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_INFRAME;
         sef_q   <= 1'b0;
         run_q   <= '0;
         lcnt_q  <= '0;
      end else begin
         state_q <= state_n;
         sef_q   <= sef_n;
         run_q   <= run_n;
         lcnt_q  <= lcnt_n;
      end
   end

   assign sef_o = sef_q;
   assign lof_o = lof_q;

   assert_sef_on_verdict_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(sef_o) |-> $past(frame_done_i));

   assert_sef_rise_bad_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(sef_o) |-> $past(frame_bad_i));

   assert_sef_fall_good_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(sef_o) |-> !$past(frame_bad_i));

   assert_lof_rise_with_sef_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(lof_o) |-> (sef_o && $past(sef_o)));

   assert_lof_fall_without_sef_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(lof_o) |-> (!sef_o && !$past(sef_o)));
endmodule

// File: rtl/frm_irq_regs.sv
// Status byte, sticky change-of-defect interrupt byte, read port, interrupt line.
module frm_irq_regs
   import frm_loss_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int STATUS_ADDR = 0,
   parameter int INT_ADDR    = 1,
   parameter bit READ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DEF_W-1:0]  defect_i,
   input  logic [DEF_W-1:0]  int_mask_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [REG_W-1:0]  rd_data_o,
   output logic              irq_n_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(INT_ADDR);

   if (STATUS_ADDR == INT_ADDR || STATUS_ADDR >= (1 << ADDR_W) || INT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("frm_irq_regs: register addresses must differ and fit ADDR_W");
   end

   logic [DEF_W-1:0] prev_q;
   logic [DEF_W-1:0] int_q;
   logic             clr_rd;
   logic             stat_rd;
   logic [REG_W-1:0] rd_mux;

   assign clr_rd  = rd_en_i && (rd_addr_i == A_INT);
   assign stat_rd = rd_en_i && (rd_addr_i == A_STAT);

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= defect_i;
   end

   for (genvar b = 0; b < DEF_W; b++) begin : g_int
      // a change on the read edge wins over the clear
      always_ff @(posedge clk) begin
         if (rst) int_q[b] <= 1'b0;
         else     int_q[b] <= (int_q[b] && !clr_rd) || (defect_i[b] != prev_q[b]);
      end

      assert_int_on_change_R8: assert property (@(posedge clk) disable iff (rst)
         !$stable(defect_i[b]) |=> int_q[b]);
   end

   always_comb begin
      rd_mux = '0;
      if (rd_addr_i == A_STAT)     rd_mux[DEF_W-1:0] = defect_i;
      else if (rd_addr_i == A_INT) rd_mux[DEF_W-1:0] = int_q;
   end

   if (READ_REG) begin : g_rd_reg
      logic [REG_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (rst)          rd_q <= '0;
         else if (rd_en_i) rd_q <= rd_mux;
      end
      assign rd_data_o = rd_q;
   end else begin : g_rd_comb
      assign rd_data_o = rd_en_i ? rd_mux : '0;
   end

   assign irq_n_o = ~|(int_q & int_mask_i);

   assert_int_clears_R9: assert property (@(posedge clk) disable iff (rst)
      (clr_rd && (defect_i == prev_q)) |=> (int_q == '0));

   assert_status_read_keeps_R9: assert property (@(posedge clk) disable iff (rst)
      (stat_rd && (defect_i == prev_q)) |=> $stable(int_q));
endmodule

// File: rtl/frm_loss_mon.sv
module frm_loss_mon
   import frm_loss_pkg::*;
#(
   parameter int         A1_COUNT       = 3,
   parameter int         A2_COUNT       = 3,
   parameter logic [7:0] A1_VAL         = 8'hF6,
   parameter logic [7:0] A2_VAL         = 8'h28,
   parameter int         SEF_SET_FRAMES = 4,
   parameter int         SEF_CLR_FRAMES = 2,
   parameter int         LOF_FRAMES     = 24,
   parameter int         ADDR_W         = 2,
   parameter int         STATUS_ADDR    = 0,
   parameter int         INT_ADDR       = 1,
   parameter bit         READ_REG       = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              los_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   input  logic              fsync_i,
   input  logic [2:0]        int_mask_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              irq_n_o
);
   logic             los_q;
   logic             frame_done;
   logic             frame_bad;
   logic             sef;
   logic             lof;
   logic [DEF_W-1:0] defect;

   always_ff @(posedge clk) begin
      if (rst) los_q <= 1'b0;
      else     los_q <= los_i;
   end

   frm_align_chk #(
      .A1_COUNT (A1_COUNT),
      .A2_COUNT (A2_COUNT),
      .A1_VAL   (A1_VAL),
      .A2_VAL   (A2_VAL)
   ) u_chk (
      .clk          (clk),
      .rst          (rst),
      .byte_vld_i   (byte_vld_i),
      .byte_i       (byte_i),
      .fsync_i      (fsync_i),
      .frame_done_o (frame_done),
      .frame_bad_o  (frame_bad)
   );

   frm_defect_fsm #(
      .SEF_SET_FRAMES (SEF_SET_FRAMES),
      .SEF_CLR_FRAMES (SEF_CLR_FRAMES),
      .LOF_FRAMES     (LOF_FRAMES)
   ) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .frame_done_i (frame_done),
      .frame_bad_i  (frame_bad),
      .sef_o        (sef),
      .lof_o        (lof)
   );

   always_comb begin
      defect          = '0;
      defect[BIT_LOS] = los_q;
      defect[BIT_SEF] = sef;
      defect[BIT_LOF] = lof;
   end

   frm_irq_regs #(
      .ADDR_W      (ADDR_W),
      .STATUS_ADDR (STATUS_ADDR),
      .INT_ADDR    (INT_ADDR),
      .READ_REG    (READ_REG)
   ) u_regs (
      .clk        (clk),
      .rst        (rst),
      .defect_i   (defect),
      .int_mask_i (int_mask_i),
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o),
      .irq_n_o    (irq_n_o)
   );

   assert_los_follows_R11: assert property (@(posedge clk) disable iff (rst)
      !$stable(los_q) |-> ($past(los_i) == los_q));
endmodule

// File: tb/sim_frm_loss_mon.sv
module sim_frm_loss_mon;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       los = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_d = 8'h00;
   logic       fsync = 1'b0;
   logic [2:0] mask = 3'b111;
   logic       rd_en = 1'b0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       irq_n;

   int n_tests = 0;
   int n_fail  = 0;

   // reference state
   bit       m_sef = 0, m_lof = 0, m_los = 0;
   int       m_run = 0, m_lcnt = 0;
   bit [2:0] m_int = '0;

   always #5 clk = ~clk;

   frm_loss_mon u0 (
      .clk (clk), .rst (rst), .los_i (los), .byte_vld_i (byte_vld),
      .byte_i (byte_d), .fsync_i (fsync), .int_mask_i (mask),
      .rd_en_i (rd_en), .rd_addr_i (rd_addr), .rd_data_o (rd_data),
      .irq_n_o (irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_en = 1'b1;
      rd_addr = a;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   function automatic logic [7:0] exp_status();
      return {5'b0, m_lof, m_sef, m_los};
   endfunction

   function automatic logic exp_irq_n();
      return ~|(m_int & mask);
   endfunction

   // per-frame persistence rules: 4 errored in a row set SEF, 2 clean clear it,
   // 24 steady frames of disagreeing SEF toggle LOF
   task automatic model_frame(input bit bad);
      bit [2:0] old_d = {m_lof, m_sef, m_los};
      bit sef_n = m_sef;
      if (!m_sef) begin
         if (bad) begin
            if (m_run + 1 == 4) begin sef_n = 1; m_run = 0; end
            else m_run++;
         end else m_run = 0;
      end else begin
         if (!bad) begin
            if (m_run + 1 == 2) begin sef_n = 0; m_run = 0; end
            else m_run++;
         end else m_run = 0;
      end
      if (sef_n != m_sef) m_lcnt = 0;
      else if (m_sef != m_lof) begin
         if (m_lcnt + 1 == 24) begin m_lof = !m_lof; m_lcnt = 0; end
         else m_lcnt++;
      end else m_lcnt = 0;
      m_sef = sef_n;
      m_int |= old_d ^ {m_lof, m_sef, m_los};
   endtask

   // bad_pos < 0: clean frame; otherwise one bit flipped in that framing byte
   task automatic push_frame(input int bad_pos);
      for (int i = 0; i < 6; i++) begin
         logic [7:0] v;
         if ($urandom % 4 == 0) begin
            byte_vld = 1'b0;
            byte_d = 8'($urandom);
            fsync = 1'($urandom);
            tick();
         end
         v = (i < 3) ? 8'hF6 : 8'h28;
         if (i == bad_pos) v = v ^ 8'(1 << ($urandom % 8));
         byte_vld = 1'b1;
         byte_d = v;
         fsync = (i == 0);
         tick();
      end
      byte_vld = 1'b0;
      fsync = 1'b0;
      model_frame(bad_pos >= 0);
   endtask

   task automatic filler();
      for (int i = 0; i < 2; i++) begin
         byte_vld = 1'b1;
         byte_d = 8'($urandom);
         fsync = 1'b0;
         tick();
      end
      byte_vld = 1'b0;
   endtask

   task automatic frame_chk(input int bad_pos, input string req);
      logic [7:0] d;
      push_frame(bad_pos);
      filler();
      rd(2'd0, d);
      chk({req, " status"}, d, exp_status());
      chk({req, " irq_n"}, irq_n, exp_irq_n());
   endtask

   task automatic int_chk(input string req);
      logic [7:0] d;
      rd(2'd1, d);
      chk(req, d, {5'b0, m_int});
      m_int = '0;
   endtask

   function automatic int bad_any();
      return int'($urandom % 6);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); chk("R1 status after reset", d, 8'h00);
      rd(2'd1, d); chk("R1 int after reset", d, 8'h00);
      chk("R1 irq_n after reset", irq_n, 1'b1);

      // R3: three errored, one clean, three errored -> no SEF
      for (int i = 0; i < 3; i++) frame_chk(bad_any(), "R3");
      frame_chk(-1, "R3");
      for (int i = 0; i < 3; i++) frame_chk(bad_any(), "R3");
      chk("R3 sef still clear", m_sef, 1'b0);

      // R4: fourth errored in a row sets SEF; R8/R10 interrupt
      frame_chk(bad_any(), "R4");
      chk("R4 sef expected set", m_sef, 1'b1);
      chk("R10 irq_n low with pending sef", irq_n, 1'b0);
      rd(2'd0, d); chk("R9 status read twice", d, exp_status());
      int_chk("R8 sef change bit1");
      int_chk("R9 int cleared after read");
      chk("R10 irq_n high after clear", irq_n, 1'b1);

      // R5: clean, errored, clean keeps SEF; two clean clear it
      frame_chk(-1, "R5");
      frame_chk(bad_any(), "R5");
      frame_chk(-1, "R5");
      chk("R5 sef held", m_sef, 1'b1);
      frame_chk(-1, "R5");
      chk("R5 sef cleared", m_sef, 1'b0);
      int_chk("R8 sef fall sets bit1");

      // R6: hold SEF for 24 judged frames
      for (int i = 0; i < 4; i++) frame_chk(bad_any(), "R4");
      for (int i = 0; i < 23; i++) frame_chk(bad_any(), "R6");
      chk("R6 lof not yet at 23", m_lof, 1'b0);
      frame_chk(bad_any(), "R6");
      chk("R6 lof at 24", m_lof, 1'b1);
      int_chk("R8 sef and lof rise");

      // R10: masked bits latch but keep irq_n high
      mask = 3'b000;
      for (int i = 0; i < 2; i++) frame_chk(-1, "R5");
      chk("R10 masked irq_n high", irq_n, 1'b1);
      mask = 3'b010;
      #1 chk("R10 unmasked sef pending", irq_n, 1'b0);
      mask = 3'b111;

      // R7: LOF clears after 24 frames with SEF clear
      for (int i = 0; i < 23; i++) frame_chk(-1, "R7");
      chk("R7 lof still set at 23", m_lof, 1'b1);
      frame_chk(-1, "R7");
      chk("R7 lof cleared at 24", m_lof, 1'b0);
      int_chk("R8 sef fall and lof fall");

      // R11: LOS passes through to bit 0
      los = 1'b1; m_los = 1; m_int[0] = 1'b1;
      repeat (3) tick();
      rd(2'd0, d); chk("R11 los status", d, exp_status());
      int_chk("R11 los change bit0");
      los = 1'b0; m_los = 0; m_int[0] = 1'b1;
      repeat (3) tick();
      rd(2'd0, d); chk("R11 los status clear", d, exp_status());
      int_chk("R8 los fall bit0");

      // R2: every byte position and every bit can make a frame errored
      for (int p = 0; p < 6; p++) begin
         for (int i = 0; i < 4; i++) frame_chk(p, "R2");
         chk("R2 errored position sets sef", m_sef, 1'b1);
         frame_chk(-1, "R2");
         frame_chk(-1, "R2");
      end
      int_chk("R8 after position sweep");

      // R12: an aborted window is dropped and the restarted frame counts
      for (int i = 0; i < 4; i++) frame_chk(bad_any(), "R12");
      for (int k = 0; k < 2; k++) begin
         byte_vld = 1'b1; fsync = 1'b1; byte_d = 8'h00; tick();
         fsync = 1'b0; byte_d = 8'h11; tick();
         frame_chk(-1, "R12 restarted frame");
      end
      chk("R12 sef cleared by restarted frames", m_sef, 1'b0);
      int_chk("R12 int after restart");

      // R9: SEF change lands on the clearing read
      for (int i = 0; i < 3; i++) frame_chk(bad_any(), "R9");
      push_frame(bad_any());
      tick();
      rd(2'd1, d);
      chk("R9 collision read returns old", d, 8'h00);
      int_chk("R9 collision bit survives");
      for (int i = 0; i < 2; i++) frame_chk(-1, "R5");
      int_chk("R9 cleanup");

      // random phase: alternating clean and errored stretches
      for (int n = 0; n < 400; n++) begin
         int pct;
         pct = ((n / 40) % 2 == 0) ? 10 : 85;
         if (n % 20 == 0) mask = 3'($urandom);
         if ($urandom % 50 == 0) begin
            los = ~los; m_los = ~m_los; m_int[0] = 1'b1;
         end
         if (($urandom % 100) < pct) frame_chk(bad_any(), "R6 random");
         else frame_chk(-1, "R7 random");
         if ($urandom % 8 == 0) int_chk("R9 random int read");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule